// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the operating mode of a small microcontroller and turns it into clock gate enables, a stop request to the peripherals, a regulator-mode select and a bus-frequency limit flag. Two run modes exist: normal run and very-low-power run. Each run mode has its own wait mode and its own stop mode. A wait-for-interrupt event takes the block out of a run mode. A deep-sleep select input decides whether that event leads to wait or to stop.

Wait gates only the core clock. Stop happens in two steps. The core clock and the system clock to the core are gated at once, and a stop request goes out to the peripherals. The system clock to the other bus masters and the bus clocks are gated only once every peripheral acknowledges that request. A wakeup pulse brings the block back to the run mode it left, and it does so even if the acknowledges are not yet complete. A run-mode select write switches between the two run modes, and only while a run mode is active. Regulator selection and the frequency limit follow the very-low-power flag of the mode.

Top module: `pmseq_top`

## Requirements
- R1: After reset the mode code is 3'b000 (normal run), all four clock enables are 1, and stop request, stop-regulation select and frequency limit are 0.
- R2: A wait-for-interrupt pulse with deep-sleep select 0 in a run mode enters the matching wait mode (code bit 2 kept, bits 1:0 = 01). There the core clock enable is 0 while the system-core, system-master and bus enables stay 1 and stop request stays 0.
- R3: A wait-for-interrupt pulse with deep-sleep select 1 in a run mode enters the matching stop mode (bits 1:0 = 10). From the next edge the core and system-core enables are 0, stop request is 1, and system-master and bus enables are still 1.
- R4: In a stop mode the system-master and bus enables go to 0 one edge after a cycle in which every stop-acknowledge bit is 1. While any bit is 0 they stay at 1.
- R5: A run-mode write with select 1 in normal run enters very-low-power run (code 3'b100). A write with select 0 in very-low-power run returns to normal run (3'b000).
- R6: A run-mode write in any wait or stop mode has no effect on the mode or on the outputs.
- R7: Stop-regulation select and frequency limit are 1 in every very-low-power mode (code bit 2 = 1) and 0 in every normal mode.
- R8: A wakeup pulse in a wait or stop mode returns to the run mode with the same code bit 2. From the next edge all clock enables are 1 and stop request is 0.
- R9: A wakeup pulse in a stop mode before all acknowledges are seen aborts the entry and returns to run. A wakeup in the same cycle as the last acknowledge also wins.
- R10: When a wait-for-interrupt pulse and a run-mode write arrive in the same run-mode cycle, the wait-for-interrupt is taken and the write is dropped.
- R11: A wakeup pulse in a run mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_i | input | 1 | Wait-for-interrupt event pulse |
| deep_sel_i | input | 1 | 0 selects wait, 1 selects stop on wfi_i |
| runm_wr_i | input | 1 | Run-mode select write strobe |
| runm_sel_i | input | 1 | Written run mode: 0 normal, 1 very-low-power |
| wake_i | input | 1 | Wakeup pulse |
| stop_ack_i | input | N_PERIPH | Per-peripheral stop acknowledge |
| core_clk_en_o | output | 1 | Core clock enable |
| sys_core_clk_en_o | output | 1 | System clock enable to the core |
| sys_mst_clk_en_o | output | 1 | System clock enable to other masters |
| bus_clk_en_o | output | 1 | Bus clock enable |
| stop_req_o | output | 1 | Stop request broadcast to peripherals |
| reg_stop_o | output | 1 | 1 selects stop regulation, 0 run regulation |
| freq_limit_o | output | 1 | Bus frequency limit flag |
| mode_o | output | 3 | Mode code: bit 2 very-low-power, bits 1:0 run 00 / wait 01 / stop 10 |

## Verification
Every output is decoded from a single state register. A wfi, write or wakeup pulse therefore shows its result one clock edge after the cycle in which it is held. Bus gating in stop appears one edge after the first cycle with a full acknowledge set. The bench drives each pulse for exactly one cycle from a falling edge and compares all outputs at the next falling edge. To show that no early gating occurs, it holds partial acknowledge patterns for several cycles and samples after each one.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_WAIT = 2'd1,
        PH_STOP = 2'd2
    } phase_e;

    typedef struct packed {
        logic   vlp;
        phase_e phase;
        logic   bus_off;
    } pm_state_t;

    localparam pm_state_t PM_RESET = '{vlp: 1'b0, phase: PH_RUN, bus_off: 1'b0};

    typedef struct packed {
        logic core;
        logic sys_core;
        logic sys_mst;
        logic bus;
    } clk_en_t;

    function automatic logic [2:0] mode_code(input pm_state_t s);
        return {s.vlp, s.phase};
    endfunction

endpackage

// File: rtl/pmseq_ack_collect.sv
module pmseq_ack_collect #(
    parameter int N_PERIPH = 4
) (
    input  logic [N_PERIPH-1:0] ack_i,
    output logic                all_o
);
    logic [N_PERIPH:0] chain;
    assign chain[0] = 1'b1;

    for (genvar i = 0; i < N_PERIPH; i++) begin : g_and
        assign chain[i+1] = chain[i] & ack_i[i];
    end

    assign all_o = chain[N_PERIPH];
endmodule

// File: rtl/pmseq_mode_fsm.sv
module pmseq_mode_fsm
    import pmseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wfi_i,
    input  logic      deep_sel_i,
    input  logic      runm_wr_i,
    input  logic      runm_sel_i,
    input  logic      wake_i,
    input  logic      all_ack_i,
    output pm_state_t state_o
);
    pm_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_RUN: begin
                if (wfi_i) begin
                    st_d.phase   = deep_sel_i ? PH_STOP : PH_WAIT;
                    st_d.bus_off = 1'b0;
                end else if (runm_wr_i) begin
                    st_d.vlp = runm_sel_i;
                end
            end
            PH_WAIT: begin
                if (wake_i) st_d.phase = PH_RUN;
            end
            PH_STOP: begin
                if (wake_i) begin
                    st_d.phase   = PH_RUN;
                    st_d.bus_off = 1'b0;
                end else if (all_ack_i) begin
                    st_d.bus_off = 1'b1;
                end
            end
            default: st_d = PM_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PM_RESET;
        else     st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/pmseq_out_decode.sv
module pmseq_out_decode
    import pmseq_pkg::*;
(
    input  pm_state_t   state_i,
    output clk_en_t     en_o,
    output logic        stop_req_o,
    output logic        reg_stop_o,
    output logic        freq_limit_o,
    output logic [2:0]  mode_o
);
    logic in_stop, gated;

    always_comb begin
        in_stop          = (state_i.phase == PH_STOP);
        gated            = in_stop && state_i.bus_off;
        en_o.core        = (state_i.phase == PH_RUN);
        en_o.sys_core    = !in_stop;
        en_o.sys_mst     = !gated;
        en_o.bus         = !gated;
        stop_req_o       = in_stop;
        reg_stop_o       = state_i.vlp;
        freq_limit_o     = state_i.vlp;
        mode_o           = mode_code(state_i);
    end
endmodule

// File: rtl/pmseq_top.sv
module pmseq_top
    import pmseq_pkg::*;
#(
    parameter int N_PERIPH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wfi_i,
    input  logic                deep_sel_i,
    input  logic                runm_wr_i,
    input  logic                runm_sel_i,
    input  logic                wake_i,
    input  logic [N_PERIPH-1:0] stop_ack_i,
    output logic                core_clk_en_o,
    output logic                sys_core_clk_en_o,
    output logic                sys_mst_clk_en_o,
    output logic                bus_clk_en_o,
    output logic                stop_req_o,
    output logic                reg_stop_o,
    output logic                freq_limit_o,
    output logic [2:0]          mode_o
);
    logic      all_ack;
    pm_state_t state;
    clk_en_t   en;

    pmseq_ack_collect #(.N_PERIPH(N_PERIPH)) u_ack (
        .ack_i (stop_ack_i),
        .all_o (all_ack)
    );

    pmseq_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wfi_i      (wfi_i),
        .deep_sel_i (deep_sel_i),
        .runm_wr_i  (runm_wr_i),
        .runm_sel_i (runm_sel_i),
        .wake_i     (wake_i),
        .all_ack_i  (all_ack),
        .state_o    (state)
    );

    pmseq_out_decode u_dec (
        .state_i      (state),
        .en_o         (en),
        .stop_req_o   (stop_req_o),
        .reg_stop_o   (reg_stop_o),
        .freq_limit_o (freq_limit_o),
        .mode_o       (mode_o)
    );

    assign core_clk_en_o     = en.core;
    assign sys_core_clk_en_o = en.sys_core;
    assign sys_mst_clk_en_o  = en.sys_mst;
    assign bus_clk_en_o      = en.bus;
endmodule

// File: rtl/pmseq_chk.sv
module pmseq_chk #(
    parameter int N_PERIPH = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                wfi_i,
    input logic                deep_sel_i,
    input logic                runm_wr_i,
    input logic                runm_sel_i,
    input logic                wake_i,
    input logic [N_PERIPH-1:0] stop_ack_i,
    input logic                core_clk_en_o,
    input logic                sys_core_clk_en_o,
    input logic                sys_mst_clk_en_o,
    input logic                bus_clk_en_o,
    input logic                stop_req_o,
    input logic                reg_stop_o,
    input logic                freq_limit_o,
    input logic [2:0]          mode_o
);
    logic in_run;
    assign in_run = (mode_o[1:0] == 2'b00);

    // R2
    wait_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && wfi_i && !deep_sel_i) |=>
        (!core_clk_en_o && sys_core_clk_en_o && bus_clk_en_o && !stop_req_o));

    // R3
    stop_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && wfi_i && deep_sel_i) |=>
        (!core_clk_en_o && !sys_core_clk_en_o && stop_req_o && bus_clk_en_o));

    // R4
    bus_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_req_o && (&stop_ack_i) && !wake_i) |=> (!bus_clk_en_o && !sys_mst_clk_en_o));

    // R4
    bus_gate_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_clk_en_o) |-> $past(&stop_ack_i));

    // R5
    vlp_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && !wfi_i && runm_wr_i && runm_sel_i) |=> (mode_o == 3'b100));

    // R6
    wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_run && runm_wr_i && !wake_i && !stop_req_o) |=> $stable(mode_o));

    // R7
    vlp_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && !wfi_i && runm_wr_i && runm_sel_i) |=> (reg_stop_o && freq_limit_o));

    // R8
    wake_return_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_run && wake_i) |=>
        (core_clk_en_o && sys_core_clk_en_o && sys_mst_clk_en_o && bus_clk_en_o &&
         !stop_req_o && (mode_o[1:0] == 2'b00) && (mode_o[2] == $past(mode_o[2]))));

    // R11
    wake_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && wake_i && !wfi_i && !runm_wr_i) |=> $stable(mode_o));
endmodule

bind pmseq_top pmseq_chk #(.N_PERIPH(N_PERIPH)) u_chk (
    .clk               (clk),
    .rst               (rst),
    .wfi_i             (wfi_i),
    .deep_sel_i        (deep_sel_i),
    .runm_wr_i         (runm_wr_i),
    .runm_sel_i        (runm_sel_i),
    .wake_i            (wake_i),
    .stop_ack_i        (stop_ack_i),
    .core_clk_en_o     (core_clk_en_o),
    .sys_core_clk_en_o (sys_core_clk_en_o),
    .sys_mst_clk_en_o  (sys_mst_clk_en_o),
    .bus_clk_en_o      (bus_clk_en_o),
    .stop_req_o        (stop_req_o),
    .reg_stop_o        (reg_stop_o),
    .freq_limit_o      (freq_limit_o),
    .mode_o            (mode_o)
);

// File: tb/pmseq_top_tb.sv
module pmseq_top_tb;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wfi = 1'b0, deep = 1'b0, wr = 1'b0, sel = 1'b0, wake = 1'b0;
    logic [NP-1:0] ack = '0;
    logic core_en, sysc_en, sysm_en, bus_en, sreq, regs, lim;
    logic [2:0] mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pmseq_top #(.N_PERIPH(NP)) u_dut (
        .clk (clk), .rst (rst), .wfi_i (wfi), .deep_sel_i (deep),
        .runm_wr_i (wr), .runm_sel_i (sel), .wake_i (wake), .stop_ack_i (ack),
        .core_clk_en_o (core_en), .sys_core_clk_en_o (sysc_en),
        .sys_mst_clk_en_o (sysm_en), .bus_clk_en_o (bus_en),
        .stop_req_o (sreq), .reg_stop_o (regs), .freq_limit_o (lim), .mode_o (mode)
    );

    // Packed view: core, sys_core, sys_mst, bus, stop_req, reg_stop, limit, mode[2:0]
    localparam logic [9:0] V_RUN   = 10'b1111_0_0_0_000;
    localparam logic [9:0] V_WAIT  = 10'b0111_0_0_0_001;
    localparam logic [9:0] V_STOPA = 10'b0011_1_0_0_010;
    localparam logic [9:0] V_STOPB = 10'b0000_1_0_0_010;
    localparam logic [9:0] V_VRUN  = 10'b1111_0_1_1_100;
    localparam logic [9:0] V_VWAIT = 10'b0111_0_1_1_101;
    localparam logic [9:0] V_VSTPA = 10'b0011_1_1_1_110;
    localparam logic [9:0] V_VSTPB = 10'b0000_1_1_1_110;

    function automatic logic [9:0] outs();
        return {core_en, sysc_en, sysm_en, bus_en, sreq, regs, lim, mode};
    endfunction

    task automatic chk(input string req, input logic [9:0] exp);
        logic [9:0] act = outs();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Hold the given inputs for one cycle from a falling edge, then release.
    task automatic pulse(input logic w, input logic d, input logic r, input logic s, input logic k);
        wfi = w; deep = d; wr = r; sel = s; wake = k;
        @(negedge clk);
        wfi = 1'b0; deep = 1'b0; wr = 1'b0; sel = 1'b0; wake = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset state", V_RUN);
    endtask

    task automatic t_wait();
        pulse(1, 0, 0, 0, 0);
        chk("R2 wait entry", V_WAIT);
        pulse(0, 0, 1, 1, 0);
        chk("R6 write ignored in wait", V_WAIT);
        pulse(0, 0, 0, 0, 1);
        chk("R8 wake from wait", V_RUN);
    endtask

    task automatic t_stop();
        pulse(1, 1, 0, 0, 0);
        chk("R3 stop entry", V_STOPA);
        ack = 4'b0011;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R4 partial ack keeps bus on", V_STOPA);
        end
        ack = 4'b1111;
        @(negedge clk);
        chk("R4 bus gated after all acks", V_STOPB);
        pulse(0, 0, 1, 1, 0);
        chk("R6 write ignored in stop", V_STOPB);
        ack = 4'b0000;
        pulse(0, 0, 0, 0, 1);
        chk("R8 wake from stop", V_RUN);
    endtask

    task automatic t_abort();
        pulse(1, 1, 0, 0, 0);
        ack = 4'b0111;
        @(negedge clk);
        chk("R9 pending stop", V_STOPA);
        pulse(0, 0, 0, 0, 1);
        chk("R9 abort to run", V_RUN);
        pulse(1, 1, 0, 0, 0);
        ack = 4'b1111;
        pulse(0, 0, 0, 0, 1);
        chk("R9 wake wins over last ack", V_RUN);
        ack = 4'b0000;
    endtask

    task automatic t_vlp();
        pulse(0, 0, 1, 1, 0);
        chk("R5 R7 enter very-low-power run", V_VRUN);
        pulse(1, 0, 0, 0, 0);
        chk("R2 R7 very-low-power wait", V_VWAIT);
        pulse(0, 0, 0, 0, 1);
        chk("R8 wake to very-low-power run", V_VRUN);
        pulse(1, 1, 0, 0, 0);
        chk("R3 R7 very-low-power stop", V_VSTPA);
        ack = 4'b1111;
        @(negedge clk);
        chk("R4 very-low-power stop gated", V_VSTPB);
        ack = 4'b0000;
        pulse(0, 0, 1, 0, 0);
        chk("R6 write ignored in very-low-power stop", V_VSTPB);
        pulse(0, 0, 0, 0, 1);
        chk("R8 wake to very-low-power run from stop", V_VRUN);
        pulse(0, 0, 1, 0, 0);
        chk("R5 back to normal run", V_RUN);
    endtask

    task automatic t_prio();
        pulse(1, 0, 1, 1, 0);
        chk("R10 wfi beats write", V_WAIT);
        pulse(0, 0, 0, 0, 1);
        chk("R10 return keeps normal run", V_RUN);
    endtask

    task automatic t_wake_run();
        pulse(0, 0, 0, 0, 1);
        chk("R11 wake in run ignored", V_RUN);
        pulse(0, 0, 1, 1, 0);
        pulse(0, 0, 0, 0, 1);
        chk("R11 wake in very-low-power run ignored", V_VRUN);
        pulse(0, 0, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wait();
        t_stop();
        t_abort();
        t_vlp();
        t_prio();
        t_wake_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule